// File: doc/BRIEF.md
# Edge-Latched Address Static RAM

This block models a 256-word by 4-bit static memory with a latched interface of the kind used on microprocessor buses. An access begins when the active-low chip-enable strobe falls. On that edge the block captures the eight address inputs and holds them for the rest of the access. Two active-low chip selects and an active-low write enable then decide whether the access is a write, a read or nothing.

The captured address is split into a 5-bit row and a 3-bit column. These select one cell in each of four column groups of a 32 by 32 bit matrix, one group per data bit. Read data passes through output data latches. The shared bidirectional data pin is modelled as three separate signals: an input bus, an output bus and an output-enable flag. When the output enable is low, the output pins are in high impedance.

All control inputs are sampled by a system clock. The falling edge of chip enable is detected as a one-cycle pulse.

Top module: `latched_sram`

## Requirements
- R1: After reset, `oe_o` is 0 and `dout_o` is 0.
- R2: A write access stores `din_i` at the captured address, and a later read access returns it. The access is started by driving `ce_n_i` from 1 to 0 while both selects are 0. In the access, the write happens when `we_n_i` is 0 and the read when `we_n_i` is 1. Read data and `oe_o`=1 appear on the second rising clock edge after `ce_n_i` is first low.
- R3: The address is captured on the first rising clock edge where `ce_n_i` is low after being high. Later changes of `addr_i` while `ce_n_i` stays low have no effect on the access.
- R4: Row = {addr[7],addr[6],addr[5],addr[1],addr[0]} and column = {addr[4],addr[3],addr[2]}. Every one of the 256 addresses holds its own 4-bit word.
- R5: While `we_n_i` is 0 in an access, `oe_o` stays 0.
- R6: If either select is 1, `oe_o` is 0 and a write attempt leaves memory unchanged.
- R7: While `ce_n_i` is 1, `oe_o` is 0 and `dout_o` holds the last value read.
- R8: Stored contents are kept across any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| addr_i | input | 8 | Word address |
| ce_n_i | input | 1 | Active-low chip-enable strobe; its fall starts an access |
| we_n_i | input | 1 | Active-low write enable |
| sel1_n_i | input | 1 | Active-low chip select 1 |
| sel2_n_i | input | 1 | Active-low chip select 2 |
| din_i | input | 4 | Write data |
| dout_o | output | 4 | Read data from the output latches |
| oe_o | output | 1 | Output enable; 0 means the data pins are in high impedance |

## Verification
The falling strobe is seen at the first rising edge, which also captures the address. A write lands in the array on the second edge. Read data and the output enable become visible just after that second edge. The gating of `oe_o` by the strobe and the selects applies immediately.

The bench drives every input on the falling clock edge and waits two falling edges before it checks read data or the write-time output enable. It checks deselection and release one falling edge after the change.

// File: rtl/sram_pkg.sv
package sram_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2
   } cyc_kind_t;
endpackage

// File: rtl/sram_addr_latch.sv
module sram_addr_latch #(
   parameter int unsigned ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] ROW_MASK = 8'b1110_0011,
   parameter int unsigned ROW_BITS = 5,
   parameter int unsigned COL_BITS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ce_n_i,
   input  logic [ADDR_W-1:0]   addr_i,
   output logic                fall_o,
   output logic                active_o,
   output logic [ROW_BITS-1:0] row_o,
   output logic [COL_BITS-1:0] col_o
);
   logic              ce_q;
   logic              active_q;
   logic [ADDR_W-1:0] addr_q;

   initial begin
      assert ($countones(ROW_MASK) == ROW_BITS)
         else $error("row mask does not match ROW_BITS");
      assert (ROW_BITS + COL_BITS == ADDR_W)
         else $error("row and column widths must cover the address");
   end

   function automatic logic [ROW_BITS-1:0] pick_row(input logic [ADDR_W-1:0] a);
      logic [ROW_BITS-1:0] r;
      int k;
      r = '0;
      k = 0;
      for (int i = 0; i < ADDR_W; i++) begin
         if (ROW_MASK[i]) begin
            r[k] = a[i];
            k++;
         end
      end
      return r;
   endfunction

   function automatic logic [COL_BITS-1:0] pick_col(input logic [ADDR_W-1:0] a);
      logic [COL_BITS-1:0] c;
      int k;
      c = '0;
      k = 0;
      for (int i = 0; i < ADDR_W; i++) begin
         if (!ROW_MASK[i]) begin
            c[k] = a[i];
            k++;
         end
      end
      return c;
   endfunction

   assign fall_o = ce_q & ~ce_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q     <= 1'b1;
         active_q <= 1'b0;
         addr_q   <= '0;
      end else begin
         ce_q <= ce_n_i;
         if (fall_o) begin
            addr_q   <= addr_i;
            active_q <= 1'b1;
         end else if (ce_n_i) begin
            active_q <= 1'b0;
         end
      end
   end

   assign active_o = active_q & ~ce_n_i;
   assign row_o    = pick_row(addr_q);
   assign col_o    = pick_col(addr_q);

   // R3
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);

   // R3
   addr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n_i && !fall_o) |=> $stable(row_o) && $stable(col_o));
endmodule

// File: rtl/sram_cell_array.sv
module sram_cell_array #(
   parameter int unsigned DATA_W   = 4,
   parameter int unsigned ROW_BITS = 5,
   parameter int unsigned COL_BITS = 3,
   localparam int unsigned ROWS    = 1 << ROW_BITS,
   localparam int unsigned GROUP   = 1 << COL_BITS
) (
   input  logic                clk,
   input  logic                we_i,
   input  logic [ROW_BITS-1:0] row_i,
   input  logic [COL_BITS-1:0] col_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   rdata_o
);
   logic [ROWS-1:0] row_sel;
   logic [ROWS-1:0] row_we;

   always_comb begin
      row_sel = '0;
      row_sel[row_i] = 1'b1;
   end

   assign row_we = we_i ? row_sel : '0;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic [ROWS-1:0][GROUP-1:0] cells;
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         always_ff @(posedge clk) begin
            if (row_we[r]) cells[r][col_i] <= wdata_i[b];
         end
      end
      assign rdata_o[b] = cells[row_i][col_i];
   end

   // R4
   row_onehot_chk: assert property (@(posedge clk)
      $onehot0(row_we));
endmodule

// File: rtl/sram_out_latch.sv
module sram_out_latch #(
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              le_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (le_i) q_o <= d_i;
   end
endmodule

// File: rtl/latched_sram.sv
module latched_sram #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 4,
   parameter int unsigned ROW_BITS = 5,
   parameter logic [ADDR_W-1:0] ROW_MASK = 8'b1110_0011,
   localparam int unsigned COL_BITS = ADDR_W - ROW_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ce_n_i,
   input  logic              we_n_i,
   input  logic              sel1_n_i,
   input  logic              sel2_n_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              oe_o
);
   import sram_pkg::*;

   logic                fall;
   logic                active;
   logic [ROW_BITS-1:0] row;
   logic [COL_BITS-1:0] col;
   logic [DATA_W-1:0]   rdata;
   logic                chip_sel;
   cyc_kind_t           kind;
   logic                oe_q;

   sram_addr_latch #(
      .ADDR_W(ADDR_W), .ROW_MASK(ROW_MASK),
      .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)
   ) u_addr (
      .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .addr_i(addr_i),
      .fall_o(fall), .active_o(active), .row_o(row), .col_o(col)
   );

   assign chip_sel = ~sel1_n_i & ~sel2_n_i;

   always_comb begin
      kind = CYC_IDLE;
      if (active && chip_sel && !fall) kind = we_n_i ? CYC_READ : CYC_WRITE;
   end

   sram_cell_array #(
      .DATA_W(DATA_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)
   ) u_array (
      .clk(clk), .we_i(kind == CYC_WRITE), .row_i(row), .col_i(col),
      .wdata_i(din_i), .rdata_o(rdata)
   );

   sram_out_latch #(.DATA_W(DATA_W)) u_olat (
      .clk(clk), .rst_n(rst_n), .le_i(kind == CYC_READ),
      .d_i(rdata), .q_o(dout_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= (kind == CYC_READ);
   end

   assign oe_o = oe_q & chip_sel & ~ce_n_i;

   // R5
   no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_o |-> $past(we_n_i));

   // R7
   oe_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_o |-> $past(!ce_n_i));

   // R7
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n_i |=> $stable(dout_o));
endmodule

// File: tb/sim_latched_sram.sv
module sim_latched_sram;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr_i = '0;
   logic       ce_n_i = 1'b1;
   logic       we_n_i = 1'b1;
   logic       sel1_n_i = 1'b0;
   logic       sel2_n_i = 1'b0;
   logic [3:0] din_i = '0;
   logic [3:0] dout_o;
   logic       oe_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   latched_sram u0 (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_n_i(ce_n_i),
      .we_n_i(we_n_i), .sel1_n_i(sel1_n_i), .sel2_n_i(sel2_n_i),
      .din_i(din_i), .dout_o(dout_o), .oe_o(oe_o)
   );

   function automatic logic [3:0] pat(input logic [7:0] a, input logic [3:0] k);
      return a[3:0] ^ a[7:4] ^ {a[0], a[7], a[2], a[5]} ^ k;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_write(input logic [7:0] a, input logic [3:0] d);
      @(negedge clk);
      addr_i = a; din_i = d; we_n_i = 1'b0; ce_n_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      // R5: no output drive during a write
      check("R5", "oe during write", {3'b0, oe_o}, 4'h0);
      ce_n_i = 1'b1; we_n_i = 1'b1;
   endtask

   task automatic do_read(input logic [7:0] a, input logic [3:0] exp, input string req);
      @(negedge clk);
      addr_i = a; we_n_i = 1'b1; ce_n_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(req, "oe on read", {3'b0, oe_o}, 4'h1);
      check(req, "read data", dout_o, exp);
      ce_n_i = 1'b1;
   endtask

   task automatic t_reset();
      // R1
      check("R1", "oe after reset", {3'b0, oe_o}, 4'h0);
      check("R1", "dout after reset", dout_o, 4'h0);
   endtask

   task automatic t_basic();
      // R2
      do_write(8'h3C, 4'hA);
      do_read(8'h3C, 4'hA, "R2");
      do_write(8'h3C, 4'h5);
      do_read(8'h3C, 4'h5, "R2");
   endtask

   task automatic t_addr_latch();
      // R3: change address after capture; data must come from captured one
      do_write(8'h11, 4'h6);
      do_write(8'h22, 4'h9);
      @(negedge clk);
      addr_i = 8'h11; we_n_i = 1'b1; ce_n_i = 1'b0;
      @(negedge clk);
      addr_i = 8'h22;
      @(negedge clk);
      check("R3", "read after addr change", dout_o, 4'h6);
      @(negedge clk);
      check("R3", "read still captured", dout_o, 4'h6);
      ce_n_i = 1'b1;
      // R3: write with address changed after capture
      @(negedge clk);
      addr_i = 8'h22; din_i = 4'h3; we_n_i = 1'b0; ce_n_i = 1'b0;
      @(negedge clk);
      addr_i = 8'h11;
      @(negedge clk);
      ce_n_i = 1'b1; we_n_i = 1'b1;
      do_read(8'h22, 4'h3, "R3");
      do_read(8'h11, 4'h6, "R3");
   endtask

   task automatic t_sweep();
      int bad;
      bad = 0;
      for (int a = 0; a < 256; a++) do_write(8'(a), pat(8'(a), 4'h0));
      for (int a = 0; a < 256; a++) begin
         @(negedge clk);
         addr_i = 8'(a); ce_n_i = 1'b0; we_n_i = 1'b1;
         @(negedge clk);
         @(negedge clk);
         if (dout_o !== pat(8'(a), 4'h0)) begin
            bad++;
            if (bad < 4) check("R4", "sweep word", dout_o, pat(8'(a), 4'h0));
         end
         ce_n_i = 1'b1;
      end
      // R4: all 256 words independent
      check("R4", "sweep mismatches", 4'(bad), 4'h0);
   endtask

   task automatic t_deselect();
      do_write(8'h40, 4'hC);
      // R6: read with select 1 high
      @(negedge clk);
      addr_i = 8'h40; sel1_n_i = 1'b1; ce_n_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R6", "oe with sel1 off", {3'b0, oe_o}, 4'h0);
      ce_n_i = 1'b1; sel1_n_i = 1'b0;
      // R6: write with select 2 high must not change memory
      @(negedge clk);
      addr_i = 8'h40; din_i = 4'h1; we_n_i = 1'b0; sel2_n_i = 1'b1; ce_n_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R6", "oe with sel2 off", {3'b0, oe_o}, 4'h0);
      ce_n_i = 1'b1; we_n_i = 1'b1; sel2_n_i = 1'b0;
      do_read(8'h40, 4'hC, "R6");
   endtask

   task automatic t_release();
      do_write(8'h81, 4'h7);
      do_read(8'h81, 4'h7, "R7");
      @(negedge clk);
      // R7: strobe high, oe off, data held
      check("R7", "oe after release", {3'b0, oe_o}, 4'h0);
      check("R7", "dout held", dout_o, 4'h7);
      addr_i = 8'h40;
      idle(3);
      check("R7", "dout still held", dout_o, 4'h7);
   endtask

   task automatic t_retain();
      idle(500);
      // R8: contents kept over idle cycles
      do_read(8'h00, pat(8'h00, 4'h0), "R8");
      do_read(8'hFF, pat(8'hFF, 4'h0), "R8");
      do_read(8'h81, 4'h7, "R8");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_basic();
      t_addr_latch();
      t_sweep();
      t_deselect();
      t_release();
      t_retain();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule